// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a flash interface. After software has started a program or erase operation in the flash device, it pulses a start strobe. The poller then decides on its own when the operation has ended and whether it worked. It does this by reading the device status over a simple request/acknowledge bus and watching one status bit. While the device is busy, that bit flips on every read. When the device is idle, it holds steady.

The poller reads the status twice per step and compares the toggle bit between the two reads. If the bit keeps flipping, the poller looks at two error/timeout flag bits in the newer read. When either flag is set, the poller performs one more pair of reads before it decides, because the flip can stop in the same moment the flag appears. A failed operation always ends with a recovery command write that returns the device to read mode. A configuration input chosen at start time can request the same write after a success. A poll-count limit turns a device that never finishes into a failure.

Top module: `toggle_poller`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `done_o`, `pass_o`, `fail_o` and `bus_req_o` are all low.
- R2: Every status read is a bus request with `bus_we_o` low and `bus_addr_o` equal to `STAT_ADDR`. A request keeps `bus_req_o`, `bus_we_o` and `bus_addr_o` steady until the cycle in which `bus_ack_i` is high. A start seen while idle begins with a pair of such reads.
- R3: If bit 6 has the same value in both reads of a pair, the operation is a success. All other bits are ignored for this comparison.
- R4: If bit 6 differs within a pair and bits 3 and 5 of the second read are both 0, the poller issues another pair of reads.
- R5: If bit 6 differs within a pair and bit 3 or bit 5 of the second read is 1, the poller issues exactly one more pair of reads. A steady bit 6 in that pair gives success.
- R6: If bit 6 still differs in that extra pair, the result is a failure.
- R7: Every failure issues exactly one write of `EXIT_CMD` to `EXIT_ADDR` before `done_o` rises.
- R8: A success issues the same single write when `exit_on_pass_i` was 1 at the start strobe, and no write when it was 0. Changes to `exit_on_pass_i` after the start strobe have no effect.
- R9: After `MAX_POLLS` consecutive pairs that differ with both flag bits 0, the result is a failure.
- R10: `done_o` is high for exactly one cycle per operation, and the bus is quiet in that cycle. `pass_o` and `fail_o` are never both high. They take the result at `done_o` and hold it until the next accepted start.
- R11: A start strobe during an operation is ignored. It changes neither the number of bus transactions nor the number of `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| exit_on_pass_i | input | 1 | 1: also write the exit command after a success (sampled at start) |
| bus_req_o | output | 1 | Bus transaction request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Write data (exit command) |
| bus_ack_i | input | 1 | Transaction complete; read data valid in this cycle |
| bus_rdata_i | input | DATA_W | Status word returned by a read |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| pass_o | output | 1 | Operation succeeded |
| fail_o | output | 1 | Operation failed or poll limit reached |

## Verification
The checker assumes that the flash interface raises `bus_ack_i` only while a request is pending and for one cycle per transaction. Its hold and address properties depend on this. The bench's device model acknowledges a pending request one cycle after it sees it, then drops the acknowledge, so it never acknowledges a request that does not exist. The model builds each status word from a read index, using a toggle count and a flag onset chosen per scenario. It also changes unrelated status bits, so the comparisons see realistic words.

// File: rtl/tbp_pkg.sv
// Package: shared types for the toggle-bit completion poller.
// Assumes nothing beyond being compiled before the modules that import it.
package tbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD1   = 3'd1,
        ST_RD2   = 3'd2,
        ST_CHK1  = 3'd3,
        ST_CHK2  = 3'd4,
        ST_EXIT  = 3'd5
    } tbp_state_e;

    typedef enum logic [1:0] {
        BUS_NONE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } tbp_bus_op_e;

endpackage

// File: rtl/tbp_status_eval.sv
// Module: tbp_status_eval
// Compares the stored toggle bit of the first read with the same bit of the
// second read, and reports whether either flag bit of the second read is set.
// Assumes the second read word is valid only in the acknowledge cycle; the
// caller qualifies the outputs with that cycle.
module tbp_status_eval #(
    parameter int DATA_W     = 16,
    parameter int TOGGLE_BIT = 6,
    parameter int FLAG_HI    = 5,
    parameter int FLAG_LO    = 3
) (
    input  logic              prev_tog_i,
    input  logic [DATA_W-1:0] stat_i,
    output logic              toggled_o,
    output logic              flag_o
);

    logic unused_bits;

    // Toggle comparison and flag detection on the newer status word.
    always_comb begin
        toggled_o = prev_tog_i ^ stat_i[TOGGLE_BIT];
        flag_o    = stat_i[FLAG_HI] | stat_i[FLAG_LO];
    end

    // Remaining status bits play no part in the decision.
    assign unused_bits = ^stat_i;

endmodule

// File: rtl/tbp_poll_limit.sv
// Module: tbp_poll_limit
// Counts consecutive poll pairs that ended "still busy, no flag". Raises
// expired_o on the step that would be pair number MAX_POLLS.
// Assumes clear_i and step_i are never high together.
module tbp_poll_limit #(
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Poll pair counter, cleared at each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_i && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Limit reached on this step.
    assign expired_o = step_i && (cnt_q == LAST);

endmodule

// File: rtl/tbp_bus_drive.sv
// Module: tbp_bus_drive
// Turns the requested bus operation into request, direction, address and
// write data. Assumes the op input is steady until acknowledged.
module tbp_bus_drive
    import tbp_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
    parameter logic [ADDR_W-1:0] EXIT_ADDR = '0,
    parameter logic [DATA_W-1:0] EXIT_CMD  = '0
) (
    input  tbp_bus_op_e       op_i,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);

    // Decode the operation to bus signals.
    always_comb begin
        req_o   = 1'b0;
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        case (op_i)
            BUS_READ: begin
                req_o  = 1'b1;
                addr_o = STAT_ADDR;
            end
            BUS_WRITE: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = EXIT_ADDR;
                wdata_o = EXIT_CMD;
            end
            default: begin
                req_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/toggle_poller.sv
// Module: toggle_poller (top)
// Decides when a flash program/erase has ended by reading status twice per
// step and comparing the toggle bit. If flags show up, it rechecks once.
// On failure, and on success when requested at start, it writes the exit
// command. Assumes bus_ack_i comes only while bus_req_o is high and lasts
// one cycle per transaction.
module toggle_poller
    import tbp_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int TOGGLE_BIT = 6,
    parameter int FLAG_HI    = 5,
    parameter int FLAG_LO    = 3,
    parameter int MAX_POLLS  = 1000,
    parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
    parameter logic [ADDR_W-1:0] EXIT_ADDR = 20'h00555,
    parameter logic [DATA_W-1:0] EXIT_CMD  = 16'h00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              exit_on_pass_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);

    tbp_state_e  state_q, state_d;
    tbp_bus_op_e bus_op;
    logic        prev_tog_q;
    logic        cfg_q;
    logic        pend_pass_q;
    logic        done_q, pass_q, fail_q;

    logic        accept;
    logic        load_first;
    logic        conclude;
    logic        verdict;
    logic        set_pend;
    logic        pend_val;
    logic        step;
    logic        toggled, flag, expired;

    tbp_status_eval #(
        .DATA_W    (DATA_W),
        .TOGGLE_BIT(TOGGLE_BIT),
        .FLAG_HI   (FLAG_HI),
        .FLAG_LO   (FLAG_LO)
    ) u_eval (
        .prev_tog_i(prev_tog_q),
        .stat_i    (bus_rdata_i),
        .toggled_o (toggled),
        .flag_o    (flag)
    );

    tbp_poll_limit #(
        .MAX_POLLS(MAX_POLLS)
    ) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .step_i   (step),
        .expired_o(expired)
    );

    tbp_bus_drive #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .STAT_ADDR(STAT_ADDR),
        .EXIT_ADDR(EXIT_ADDR),
        .EXIT_CMD (EXIT_CMD)
    ) u_bus (
        .op_i   (bus_op),
        .req_o  (bus_req_o),
        .we_o   (bus_we_o),
        .addr_o (bus_addr_o),
        .wdata_o(bus_wdata_o)
    );

    // Bus operation requested by the current state.
    always_comb begin
        case (state_q)
            ST_RD1, ST_RD2, ST_CHK1, ST_CHK2: bus_op = BUS_READ;
            ST_EXIT:                          bus_op = BUS_WRITE;
            default:                          bus_op = BUS_NONE;
        endcase
    end

    // Start is accepted only while idle.
    assign accept = (state_q == ST_IDLE) && start_i;

    // Next-state and verdict decisions.
    always_comb begin
        state_d    = state_q;
        load_first = 1'b0;
        conclude   = 1'b0;
        verdict    = 1'b0;
        set_pend   = 1'b0;
        pend_val   = 1'b0;
        step       = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_RD1;
            end
            ST_RD1: begin
                if (bus_ack_i) begin
                    load_first = 1'b1;
                    state_d    = ST_RD2;
                end
            end
            ST_RD2: begin
                if (bus_ack_i) begin
                    if (!toggled) begin
                        if (cfg_q) begin
                            set_pend = 1'b1;
                            pend_val = 1'b1;
                            state_d  = ST_EXIT;
                        end else begin
                            conclude = 1'b1;
                            verdict  = 1'b1;
                            state_d  = ST_IDLE;
                        end
                    end else if (flag) begin
                        state_d = ST_CHK1;
                    end else begin
                        step = 1'b1;
                        if (expired) begin
                            set_pend = 1'b1;
                            state_d  = ST_EXIT;
                        end else begin
                            state_d = ST_RD1;
                        end
                    end
                end
            end
            ST_CHK1: begin
                if (bus_ack_i) begin
                    load_first = 1'b1;
                    state_d    = ST_CHK2;
                end
            end
            ST_CHK2: begin
                if (bus_ack_i) begin
                    if (!toggled && !cfg_q) begin
                        conclude = 1'b1;
                        verdict  = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        set_pend = 1'b1;
                        pend_val = !toggled;
                        state_d  = ST_EXIT;
                    end
                end
            end
            ST_EXIT: begin
                if (bus_ack_i) begin
                    conclude = 1'b1;
                    verdict  = pend_pass_q;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, captured toggle bit, configuration and pending verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            prev_tog_q  <= 1'b0;
            cfg_q       <= 1'b0;
            pend_pass_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept)     cfg_q       <= exit_on_pass_i;
            if (load_first) prev_tog_q  <= bus_rdata_i[TOGGLE_BIT];
            if (set_pend)   pend_pass_q <= pend_val;
        end
    end

    // Result outputs: one-cycle done, held pass/fail cleared at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= conclude;
            if (accept) begin
                pass_q <= 1'b0;
                fail_q <= 1'b0;
            end else if (conclude) begin
                pass_q <= verdict;
                fail_q <= !verdict;
            end
        end
    end

    assign done_o = done_q;
    assign pass_o = pass_q;
    assign fail_o = fail_q;

endmodule

// File: rtl/tbp_checker.sv
// Module: tbp_checker
// Temporal properties of the poller's ports. Assumes bus_ack_i comes only
// with a pending request. Bound to every toggle_poller instance below.
module tbp_checker #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
    parameter logic [ADDR_W-1:0] EXIT_ADDR = '0,
    parameter logic [DATA_W-1:0] EXIT_CMD  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_ack_i,
    input logic              done_o,
    input logic              pass_o,
    input logic              fail_o
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o)); // R2
    AST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n) bus_req_o && !bus_we_o |-> bus_addr_o == STAT_ADDR); // R2
    AST_EXIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n) bus_req_o && bus_we_o |-> bus_addr_o == EXIT_ADDR && bus_wdata_o == EXIT_CMD); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R10
    AST_DONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (pass_o != fail_o) && !bus_req_o); // R10
    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pass_o && fail_o)); // R10
    AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) pass_o && !start_i |=> pass_o); // R10
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) fail_o && !start_i |=> fail_o); // R10

endmodule

bind toggle_poller tbp_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STAT_ADDR(STAT_ADDR),
    .EXIT_ADDR(EXIT_ADDR),
    .EXIT_CMD (EXIT_CMD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_ack_i  (bus_ack_i),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o)
);

// File: tb/toggle_poller_test.sv
// Bench for toggle_poller: a driver task predicts each operation's outcome
// into a queue; a monitor pops and compares when done_o pulses.
module toggle_poller_test;

    localparam int DW   = 16;
    localparam int AW   = 20;
    localparam int MAXP = 6;
    localparam logic [AW-1:0] STAT_A = 20'h01000;
    localparam logic [AW-1:0] EXIT_A = 20'h00AAA;
    localparam logic [DW-1:0] EXIT_D = 16'h00F0;
    localparam logic [DW-1:0] F5 = 16'h0020;
    localparam logic [DW-1:0] F3 = 16'h0008;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cfg = 1'b0;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_req, bus_we, done, pass, fail;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    always #10 clk = ~clk;

    toggle_poller #(
        .ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP),
        .STAT_ADDR(STAT_A), .EXIT_ADDR(EXIT_A), .EXIT_CMD(EXIT_D)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .exit_on_pass_i(cfg),
        .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
        .done_o(done), .pass_o(pass), .fail_o(fail)
    );

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit pass;
        int reads;
        int writes;
    } exp_t;
    exp_t exp_q[$];

    // Device model state
    int            m_n = 0;
    int            m_e = 0;
    logic [DW-1:0] m_emask = '0;
    int            rd_idx = 0;
    int            wr_cnt = 0;
    int            bad_wr = 0;
    int            bad_rd = 0;
    int            done_cnt = 0;
    logic          prev_done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic tog(input int idx, input int n);
        int m;
        m = (idx < n) ? idx : n;
        return m[0];
    endfunction

    function automatic logic [DW-1:0] stat(input int idx);
        logic [DW-1:0] v;
        v = 16'h1000;
        v[6] = tog(idx, m_n);
        v[0] = idx[0];
        v[7] = ~idx[0];
        if (idx >= m_e) v = v | m_emask;
        return v;
    endfunction

    function automatic exp_t predict(input int n, input int e,
                                     input logic [DW-1:0] em, input bit c);
        exp_t r;
        int   idx = 0;
        int   polls = 0;
        bit   fin = 0;
        bit   p = 0;
        while (!fin) begin
            bit a, b, er;
            a  = tog(idx, n);
            b  = tog(idx + 1, n);
            er = (em != 0) && (idx + 1 >= e);
            idx += 2;
            if (a == b) begin
                p = 1; fin = 1;
            end else if (er) begin
                p = (tog(idx, n) == tog(idx + 1, n));
                idx += 2;
                fin = 1;
            end else begin
                polls++;
                if (polls == MAXP) begin
                    p = 0; fin = 1;
                end
            end
        end
        r.pass   = p;
        r.reads  = idx;
        r.writes = (!p || c) ? 1 : 0;
        return r;
    endfunction

    // Device model: acknowledge a pending request one cycle later.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            bus_ack = 1'b1;
            if (bus_we) begin
                wr_cnt++;
                if (bus_addr != EXIT_A || bus_wdata != EXIT_D) bad_wr++;
            end else begin
                if (bus_addr != STAT_A) bad_rd++;
                bus_rdata = stat(rd_idx);
                rd_idx++;
            end
        end
    end

    // Monitor: compare each result with the next expected item.
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            done_cnt++;
            if (exp_q.size() == 0) begin
                chk(0, "R11", "unexpected done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(pass == e.pass, "R3 R5 R6 R9", "pass", pass, e.pass);
                chk(fail == !e.pass, "R6 R9", "fail", fail, !e.pass);
                chk(rd_idx == e.reads, "R2 R4 R5 R11", "read count", rd_idx, e.reads);
                chk(wr_cnt == e.writes, "R7 R8", "write count", wr_cnt, e.writes);
                chk(bad_wr == 0, "R7", "bad exit writes", bad_wr, 0);
                chk(bad_rd == 0, "R2", "bad read address", bad_rd, 0);
            end
            if (prev_done) chk(0, "R10", "done longer than one cycle", 2, 1);
        end
        prev_done = done;
    end

    task automatic run_op(input int n, input int e, input logic [DW-1:0] em,
                          input bit c, input bit extra_start);
        exp_t pr;
        int   w = 0;
        @(negedge clk);
        m_n = n; m_e = e; m_emask = em;
        rd_idx = 0; wr_cnt = 0; bad_wr = 0; bad_rd = 0;
        pr = predict(n, e, em, c);
        exp_q.push_back(pr);
        cfg = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg = ~c; // R8: must be ignored after the strobe
        if (extra_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1; // R11: strobe while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && w < 3000) begin
            @(negedge clk);
            w++;
        end
        chk(done, "R10", "done seen", done, 1);
        repeat (3) @(negedge clk);
        chk(pass == pr.pass && fail == !pr.pass, "R10", "verdict held", pass, pr.pass);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !pass && !fail && !bus_req, "R1", "outputs in reset",
            {done, pass, fail, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !pass && !fail && !bus_req, "R1", "outputs after reset",
            {done, pass, fail, bus_req}, 0);

        run_op(0, 1000, '0, 1'b0, 1'b0);  // R3 immediate success, no write
        run_op(0, 1000, '0, 1'b1, 1'b0);  // R8 success with exit write
        run_op(5, 1000, '0, 1'b0, 1'b1);  // R4 R11 several busy pairs
        run_op(3, 3, F5, 1'b0, 1'b0);     // R5 flag then steady recheck
        run_op(100, 1, F3, 1'b0, 1'b0);   // R6 flag then still toggling
        run_op(2, 1, F5, 1'b1, 1'b0);     // R5 R8 recheck success with write
        run_op(100, 1000, '0, 1'b1, 1'b0); // R9 poll limit

        repeat (5) @(negedge clk);
        chk(done_cnt == 7, "R10 R11", "done pulses", done_cnt, 7);
        chk(exp_q.size() == 0, "R10", "pending results", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", done_cnt, 7);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule